// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in in one combinational pass. It produces the sum and the carry-out. The operands are cut into 4-bit slices. Each slice summarises its columns as a group propagate and a group generate. A lookahead unit one level up turns those summaries into every slice carry-in at once. It does not wait for carries to ripple from slice to slice.

The same four-input lookahead equations serve at every level. A 16-bit build uses two levels: column terms feed slice terms, and one unit above the slices sends carries back down to them. A 64-bit build stacks one more level. There, four 16-bit groups report their own propagate and generate to a root unit. That unit supplies the carries into bits 16, 32 and 48, and each group then spreads its carry to its slices. The logic depth grows with the number of levels rather than with the word width.

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + c_i`, with both operands taken as unsigned.
- R2: `c_o` equals bit WIDTH of `a_i + b_i + c_i`, and depends on no slice carry rippling through its neighbours.
- R3: Each 4-bit slice uses column propagate `a|b` and column generate `a&b`. It forms its internal carries from its supplied carry-in with flattened two-level equations, and forms each sum bit as `a^b^carry`.
- R4: A group's propagate is the AND of its four children's propagates. Its generate is the top child's generate OR-ed with each lower child's generate masked by all propagates above it. A group with generate 1 produces a carry for any carry-in. A group with propagate 1 produces a carry when its carry-in is 1.
- R5: Every slice carry-in equals the true carry into that bit position. All of them are produced in parallel from `c_i` by the next-level lookahead unit, which uses the same equations with group terms in place of column terms.
- R6: All-ones operand plus zero plus carry-in 1 yields a sum of zero and a carry-out of 1, so a carry passes through every slice.
- R7: All-ones plus zero with carry-in 0 yields an all-ones sum and a carry-out of 0.
- R8: WIDTH must be a power of four of at least 16. WIDTH=16 builds two levels, and WIDTH=64 adds a third level whose root unit drives the 16-bit group carries.
- R9: Zero plus zero gives a sum equal to the carry-in and a carry-out of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| c_o | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder twice, once with WIDTH=16 (two levels) and once with WIDTH=64 (three levels). Both instances see the same operand stream. The 16-bit build exercises slice summaries and the second-level unit. The 64-bit build adds 16-bit group summaries and the root unit, so carries crossing bits 16, 32 and 48 come from the third level. Directed vectors walk a carry into each slice boundary, cover propagate-only and generate-only patterns, and cover the all-ones cases. Random vectors then sweep both widths.

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);

  function automatic int depth_of(input int w);
    int n, d;
    n = w;
    d = 0;
    while (n > 1) begin
      n = n / 4;
      d++;
    end
    return d;
  endfunction

  localparam int LEVELS = depth_of(WIDTH);
  localparam int TOP    = LEVELS - 1;

  // carry-ins of four siblings from their summaries and the parent carry-in
  function automatic logic [3:0] la_cins(input logic [3:0] p, input logic [3:0] g, input logic c);
    logic [3:0] r;
    r[0] = c;
    r[1] = g[0] | (p[0] & c);
    r[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c);
    r[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c);
    return r;
  endfunction

  function automatic logic grp_gen(input logic [3:0] p, input logic [3:0] g);
    return g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
  endfunction

  // upward pass: level 0 holds columns, level l holds groups of 4**l bits
  for (genvar l = 0; l < LEVELS; l++) begin : up
    localparam int N = WIDTH >> (2 * l);
    logic [N-1:0] pr;
    logic [N-1:0] gn;
    if (l == 0) begin : leaf
      assign pr = a_i | b_i;
      assign gn = a_i & b_i;
    end else begin : node
      for (genvar k = 0; k < N; k++) begin : grp
        assign pr[k] = &up[l-1].pr[4*k +: 4];
        assign gn[k] = grp_gen(up[l-1].pr[4*k +: 4], up[l-1].gn[4*k +: 4]);
      end
    end
  end

  // downward pass: dn[m] holds carry-ins of the nodes at level TOP-m
  for (genvar m = 0; m < LEVELS; m++) begin : dn
    localparam int L = TOP - m;
    localparam int N = WIDTH >> (2 * L);
    logic [N-1:0] cy;
    if (m == 0) begin : root
      assign cy = la_cins(up[L].pr, up[L].gn, c_i);
    end else begin : spread
      for (genvar k = 0; k < N / 4; k++) begin : unit
        assign cy[4*k +: 4] = la_cins(up[L].pr[4*k +: 4], up[L].gn[4*k +: 4], dn[m-1].cy[k]);
      end
    end
  end

  assign sum_o = a_i ^ b_i ^ dn[TOP].cy;
  assign c_o   = grp_gen(up[TOP].pr, up[TOP].gn) | ((&up[TOP].pr) & c_i);

  localparam int W1 = WIDTH + 1;
  logic chk_rip;
  logic [4:0] chk_slice;

  always_comb begin
    chk_rip   = c_i;
    chk_slice = '0;
    if (!$isunknown({a_i, b_i, c_i})) begin
      // R1
      sum_chk: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + W1'(c_i)))
        else $error("sum mismatch");
      for (int i = 0; i < WIDTH; i++) begin
        // R5
        slice_carry_chk: assert (dn[TOP].cy[i] == chk_rip)
          else $error("carry into bit %0d wrong", i);
        chk_rip = (a_i[i] & b_i[i]) | (chk_rip & (a_i[i] ^ b_i[i]));
      end
      for (int k = 0; k < WIDTH / 4; k++) begin
        chk_slice = {1'b0, a_i[4*k +: 4]} + {1'b0, b_i[4*k +: 4]};
        // R4
        group_gen_chk: assert (!up[1].gn[k] || chk_slice[4])
          else $error("slice %0d generate without carry", k);
        chk_slice = chk_slice + 5'd1;
        // R4
        group_prop_chk: assert (!up[1].pr[k] || chk_slice[4])
          else $error("slice %0d propagate without carry", k);
      end
    end
  end

endmodule

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] s16;
  logic        co16;
  logic [63:0] s64;
  logic        co64;

  cla_adder #(.WIDTH(16)) u_dut (
    .a_i(a[15:0]), .b_i(b[15:0]), .c_i(cin), .sum_o(s16), .c_o(co16)
  );

  cla_adder #(.WIDTH(64)) u_dut64 (
    .a_i(a), .b_i(b), .c_i(cin), .sum_o(s64), .c_o(co64)
  );

  typedef struct {
    logic [16:0] e16;
    logic [64:0] e64;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic drive(input logic [63:0] x, input logic [63:0] y, input logic c, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a = x;
    b = y;
    cin = c;
    it.e16 = {1'b0, x[15:0]} + {1'b0, y[15:0]} + 17'(c);
    it.e64 = {1'b0, x} + {1'b0, y} + 65'(c);
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks += 2;
      if ({co16, s16} !== it.e16) begin
        errors++;
        $display("FAIL %s (16-bit, R1/R2): got %h expected %h", it.tag, {co16, s16}, it.e16);
      end
      if ({co64, s64} !== it.e64) begin
        errors++;
        $display("FAIL %s (64-bit, R8): got %h expected %h", it.tag, {co64, s64}, it.e64);
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    drive(64'd0, 64'd0, 1'b0, "R9 zero");
    drive(64'd0, 64'd0, 1'b1, "R9 carry-in only");
    drive('1, 64'd0, 1'b1, "R6 all ones plus carry-in");
    drive('1, 64'd0, 1'b0, "R7 all ones no carry");
    drive('1, '1, 1'b1, "R2 maximum operands");
    drive(64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 1'b0, "R2 top generate");
    drive(64'h0000_0000_0000_0007, 64'h0000_0000_0000_0009, 1'b0, "R3 carry inside slice");
    drive(64'h0000_0000_0000_0305, 64'h0000_0000_0000_0506, 1'b0, "R3 independent slices");
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, "R4 propagate only");
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, "R4 propagate no carry-in");
    drive(64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0010, 1'b0, "R4 slice generate");
    for (int k = 1; k < 16; k++) begin
      drive((64'd1 << (4 * k)) - 64'd1, 64'd0, 1'b1, "R5 carry into slice boundary");
      drive(64'd1 << (4 * k - 1), 64'd1 << (4 * k - 1), 1'b0, "R5 generate at slice top");
    end
    drive(64'h0000_FFFF_0000_FFFF, 64'h0000_0000_0000_0001, 1'b0, "R8 carry into bit 16");
    drive(64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, "R8 carry into bit 48");
    for (int i = 0; i < 10000; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
    end
    repeat (3) @(posedge clk);
    report();
  end
endmodule